// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind an I2C bit-level front end that has already decoded bus symbols. It receives strobes for start, repeated start and stop, plus a strobe for each complete received byte, and from them decides whether this device has been addressed. It also decides in which direction the following data will flow, and whether the byte just received must be acknowledged.

One 16-bit programmed word holds either address form. When its upper five bits carry the reserved 11110b prefix, the device answers to a 10-bit address. Otherwise bits [15:9] are its 7-bit address. The 10-bit read sequence is supported: an initial write-addressed phase, then a repeated start, then a header byte with the read bit set. A general-call byte can be answered when enabled. Once an address byte fails to match, the recognizer ignores the rest of the transfer.

Top module: `i2c_addr_match`

## Requirements
- R1: After reset all outputs are 0, and received bytes have no effect until a start or repeated start strobe has been seen.
- R2: In 7-bit mode (own_addr[15:11] not 11110b), if bits [7:1] of the first byte after a start equal own_addr[15:9], then ack_req and selected are 1 from the next cycle, and read_req equals bit 0 of that byte (1 = read from the slave).
- R3: A first byte that matches nothing gives no ack_req and no selection, and every later byte is ignored until the next start, repeated start or stop.
- R4: In 10-bit mode (own_addr[15:11] = 11110b), a first byte equal to {11110b, own_addr[10:9], 0} requests an acknowledge without selecting. If the second byte then equals own_addr[7:0], it is acknowledged and the device becomes selected with read_req 0. A different second byte is neither acknowledged nor selects. own_addr[8] has no effect.
- R5: After a full 10-bit match, a repeated start followed by {11110b, own_addr[10:9], 1} is acknowledged and sets selected and read_req. The same byte after a plain start, or after a failed match, is ignored.
- R6: A first byte of 00h is acknowledged and selects the device for writing only when gc_en is 1. A first byte of 01h is never acknowledged.
- R7: A start clears selected, read_req, ack_req and the remembered 10-bit match. A repeated start clears selected, read_req and ack_req but keeps the remembered match for the next address byte only.
- R8: A stop clears selected, read_req, ack_req and the remembered match. Bytes after it are ignored until a start.
- R9: ack_req is a level that holds from the cycle after the byte strobe until the next byte strobe, start, repeated start or stop. Bytes received while selected never raise it.
- R10: start_seen, rstart_seen and stop_seen are one-cycle pulses in the cycle after the matching strobe.
- R11: When strobes coincide, stop overrides start, start overrides repeated start, and any bus condition overrides a byte strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_addr | input | 16 | Programmed address word (7-bit or 10-bit form) |
| gc_en | input | 1 | Answer the general-call byte 00h |
| start_evt | input | 1 | Start condition strobe |
| rstart_evt | input | 1 | Repeated start condition strobe |
| stop_evt | input | 1 | Stop condition strobe |
| byte_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte, MSB first as on the bus |
| ack_req | output | 1 | Drive acknowledge for the byte just received |
| selected | output | 1 | Device addressed in this transfer |
| read_req | output | 1 | Master reads from this device |
| start_seen | output | 1 | Start received pulse |
| rstart_seen | output | 1 | Repeated start received pulse |
| stop_seen | output | 1 | Stop received pulse |

## Verification
Every output is registered and is due in the first cycle after the edge that samples the strobe. ack_req and selected then hold until the next boundary, while the three event pulses last exactly one cycle. The bench applies stimulus just after a rising edge, advances a behavioural reference model on the same rising edges, and compares all six outputs against it on each falling edge. Comparison therefore always happens half a cycle after the update.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              start_evt,
  input  logic              rstart_evt,
  input  logic              stop_evt,
  input  logic              byte_valid,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              ack_req,
  output logic              selected,
  output logic              read_req,
  output logic              start_seen,
  output logic              rstart_seen,
  output logic              stop_seen
);
  localparam logic [4:0] TEN_PFX = 5'b11110;
  localparam logic [BYTE_W-1:0] GC_BYTE = '0;
  localparam logic [BYTE_W-1:0] SB_BYTE = BYTE_W'(1);

  typedef enum logic [1:0] {PH_IDLE, PH_FIRST, PH_SECOND, PH_DONE} phase_t;
  phase_t phase;
  logic   full10;

  logic ten_bit, hdr_hit, hit7, is_gc, is_sb, low_hit;
  assign ten_bit = own_addr[ADDR_W-1 -: 5] == TEN_PFX;
  assign hdr_hit = rx_byte[BYTE_W-1:1] == {TEN_PFX, own_addr[ADDR_W-6 -: 2]};
  assign hit7    = rx_byte[BYTE_W-1:1] == own_addr[ADDR_W-1 -: 7];
  assign low_hit = rx_byte == own_addr[BYTE_W-1:0];
  assign is_gc   = rx_byte == GC_BYTE;
  assign is_sb   = rx_byte == SB_BYTE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE; full10 <= 1'b0;
      ack_req <= 1'b0; selected <= 1'b0; read_req <= 1'b0;
      start_seen <= 1'b0; rstart_seen <= 1'b0; stop_seen <= 1'b0;
    end else begin
      start_seen  <= start_evt;
      rstart_seen <= rstart_evt;
      stop_seen   <= stop_evt;
      if (stop_evt) begin
        phase <= PH_IDLE; full10 <= 1'b0;
        ack_req <= 1'b0; selected <= 1'b0; read_req <= 1'b0;
      end else if (start_evt) begin
        phase <= PH_FIRST; full10 <= 1'b0;
        ack_req <= 1'b0; selected <= 1'b0; read_req <= 1'b0;
      end else if (rstart_evt) begin
        phase <= PH_FIRST;
        ack_req <= 1'b0; selected <= 1'b0; read_req <= 1'b0;
      end else if (byte_valid) begin
        ack_req <= 1'b0;
        case (phase)
          PH_FIRST: begin
            phase  <= PH_DONE;
            full10 <= 1'b0;
            if (is_sb) begin
              ack_req <= 1'b0;
            end else if (is_gc) begin
              ack_req <= gc_en; selected <= gc_en;
            end else if (ten_bit) begin
              if (hdr_hit && !rx_byte[0]) begin
                ack_req <= 1'b1; phase <= PH_SECOND;
              end else if (hdr_hit && full10) begin
                ack_req <= 1'b1; selected <= 1'b1; read_req <= 1'b1; full10 <= 1'b1;
              end
            end else if (hit7) begin
              ack_req <= 1'b1; selected <= 1'b1; read_req <= rx_byte[0];
            end
          end
          PH_SECOND: begin
            phase <= PH_DONE;
            if (low_hit) begin
              ack_req <= 1'b1; selected <= 1'b1; full10 <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_read_implies_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    read_req |-> selected);
  assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (!selected && !ack_req && !read_req));
  assert_startbyte_nack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && is_sb && !start_evt && !rstart_evt && !stop_evt) |=> !ack_req);
  assert_ack_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !byte_valid && !start_evt && !rstart_evt && !stop_evt) |=> ack_req);
  assert_start_desel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || rstart_evt) |=> !selected);
endmodule

// File: tb/i2c_addr_match_bench.sv
module i2c_addr_match_bench;
  logic clk = 0, rst_n = 0;
  logic [15:0] own_addr = 16'h0;
  logic gc_en = 0, start_evt = 0, rstart_evt = 0, stop_evt = 0, byte_valid = 0;
  logic [7:0] rx_byte = 8'h0;
  logic ack_req, selected, read_req, start_seen, rstart_seen, stop_seen;

  always #2 clk = ~clk;

  i2c_addr_match u_i2c_addr_match (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr), .gc_en(gc_en),
    .start_evt(start_evt), .rstart_evt(rstart_evt), .stop_evt(stop_evt),
    .byte_valid(byte_valid), .rx_byte(rx_byte),
    .ack_req(ack_req), .selected(selected), .read_req(read_req),
    .start_seen(start_seen), .rstart_seen(rstart_seen), .stop_seen(stop_seen));

  int compared = 0, mismatched = 0;
  string cur_req = "R1";

  // reference model: wait_lvl 0 = ignoring, 1 = expecting address, 2 = expecting low byte
  int wait_lvl = 0;
  bit m_ack = 0, m_sel = 0, m_rd = 0, m_mem = 0, m_fs = 0, m_fr = 0, m_fp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      wait_lvl = 0; m_ack = 0; m_sel = 0; m_rd = 0; m_mem = 0;
      m_fs = 0; m_fr = 0; m_fp = 0;
    end else begin
      bit was_mem;
      m_fs = start_evt; m_fr = rstart_evt; m_fp = stop_evt;
      if (stop_evt || start_evt || rstart_evt) begin
        m_ack = 0; m_sel = 0; m_rd = 0;
        wait_lvl = stop_evt ? 0 : 1;
        if (stop_evt || start_evt) m_mem = 0;
      end else if (byte_valid) begin
        m_ack = 0;
        if (wait_lvl == 2) begin
          wait_lvl = 0;
          if (rx_byte == own_addr[7:0]) begin m_ack = 1; m_sel = 1; m_mem = 1; end
        end else if (wait_lvl == 1) begin
          wait_lvl = 0; was_mem = m_mem; m_mem = 0;
          if (rx_byte == 8'h01) begin end
          else if (rx_byte == 8'h00) begin m_ack = gc_en; m_sel = gc_en; end
          else if (own_addr[15:11] == 5'b11110) begin
            if (rx_byte[7:3] == 5'b11110 && rx_byte[2:1] == own_addr[10:9]) begin
              if (rx_byte[0] == 0) begin m_ack = 1; wait_lvl = 2; end
              else if (was_mem) begin m_ack = 1; m_sel = 1; m_rd = 1; m_mem = 1; end
            end
          end else if (rx_byte[7:1] == own_addr[15:9]) begin
            m_ack = 1; m_sel = 1; m_rd = rx_byte[0];
          end
        end
      end
    end
  end

  task automatic cmp(string nm, logic act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %b expected %b", cur_req, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cmp("ack_req", ack_req, m_ack);
    cmp("selected", selected, m_sel);
    cmp("read_req", read_req, m_rd);
    cmp("start_seen", start_seen, m_fs);
    cmp("rstart_seen", rstart_seen, m_fr);
    cmp("stop_seen", stop_seen, m_fp);
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask
  task automatic clr();
    start_evt = 0; rstart_evt = 0; stop_evt = 0; byte_valid = 0;
  endtask
  task automatic do_start(); start_evt = 1; tick(); clr(); tick(); endtask
  task automatic do_rstart(); rstart_evt = 1; tick(); clr(); tick(); endtask
  task automatic do_stop(); stop_evt = 1; tick(); clr(); tick(); endtask
  task automatic do_byte(logic [7:0] b);
    rx_byte = b; byte_valid = 1; tick(); clr(); tick(2);
  endtask
  task automatic expect_now(string nm, logic act, bit exp);
    @(negedge clk);
    cmp(nm, act, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    #(200000 * 4);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    tick(3);
    cur_req = "R1";
    expect_now("ack_req reset", ack_req, 0);
    expect_now("selected reset", selected, 0);
    rst_n = 1; tick();
    own_addr = {7'h2A, 9'h0};
    do_byte({7'h2A, 1'b0});
    expect_now("selected before start", selected, 0);

    cur_req = "R2"; do_start(); do_byte({7'h2A, 1'b0});
    expect_now("selected 7b write", selected, 1);
    cur_req = "R9"; do_byte(8'h55); do_byte({7'h2A, 1'b0});
    expect_now("ack data byte", ack_req, 0);
    cur_req = "R8"; do_stop(); do_byte({7'h2A, 1'b1});
    expect_now("selected after stop", selected, 0);
    cur_req = "R2"; do_start(); do_byte({7'h2A, 1'b1});
    expect_now("read_req 7b read", read_req, 1);
    cur_req = "R7"; do_rstart(); do_byte({7'h2A, 1'b0});
    expect_now("read_req after rstart write", read_req, 0);

    cur_req = "R3"; do_start(); do_byte({7'h2B, 1'b0}); do_byte({7'h2A, 1'b0});
    expect_now("ack after mismatch", ack_req, 0);

    cur_req = "R6"; gc_en = 0; do_start(); do_byte(8'h00);
    expect_now("gc disabled ack", ack_req, 0);
    gc_en = 1; do_start(); do_byte(8'h00);
    expect_now("gc enabled selected", selected, 1);
    do_start(); do_byte(8'h01);
    expect_now("start byte ack", ack_req, 0);
    own_addr = 16'h0000; do_start(); do_byte(8'h01);
    expect_now("start byte ack addr0", ack_req, 0);

    cur_req = "R4"; own_addr = {5'b11110, 2'b10, 1'b1, 8'h5C};
    do_start(); do_byte(8'hF4);
    expect_now("hdr ack", ack_req, 1);
    do_byte(8'h5C);
    expect_now("10b selected", selected, 1);
    do_start(); do_byte(8'hF4); do_byte(8'h5D);
    expect_now("10b low mismatch", ack_req, 0);
    do_start(); do_byte(8'hF2);
    expect_now("10b hdr mismatch", ack_req, 0);
    own_addr[8] = 0; do_start(); do_byte(8'hF4); do_byte(8'h5C);
    expect_now("bit8 ignored", selected, 1);

    cur_req = "R5"; do_rstart(); do_byte(8'hF5);
    expect_now("10b read", read_req, 1);
    do_rstart(); do_byte(8'hF5);
    expect_now("10b read again", selected, 1);
    cur_req = "R7"; do_start(); do_byte(8'hF5);
    expect_now("10b read after start", ack_req, 0);
    cur_req = "R5"; do_start(); do_byte(8'hF4); do_byte(8'h11); do_rstart(); do_byte(8'hF5);
    expect_now("10b read after failed", selected, 0);

    cur_req = "R11"; start_evt = 1; stop_evt = 1; tick(); clr(); tick();
    do_byte(8'hF4);
    expect_now("stop over start", ack_req, 0);
    do_start(); do_byte(8'hF4); do_byte(8'h5C);
    start_evt = 1; rstart_evt = 1; tick(); clr(); tick(); do_byte(8'hF5);
    expect_now("start over rstart", ack_req, 0);
    do_start(); rstart_evt = 1; rx_byte = 8'hF4; byte_valid = 1; tick(); clr(); tick();
    expect_now("rstart over byte", ack_req, 0);

    cur_req = "R10"; do_start(); do_rstart(); do_stop();
    cur_req = "R9"; do_start(); do_byte(8'hF4); tick(5);
    expect_now("ack held", ack_req, 1);
    tick(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule